// File: doc/BRIEF.md
# Host Mailbox Command Sequencer

This block runs a single mailbox command from the host side. A requester presents an opcode, an input length, the output length it expects, and the mailbox payload capacity, then pulses `start`. The engine talks to the device through a simple register port. It first waits for the doorbell to be clear and checks the memory-device status word. It then writes the command register and rings the doorbell. It waits for the doorbell to drop, fetches the return code and, on success, reads back the output length that the device reports.

The engine does not move payload bytes. It reports how many output bytes the requester may copy, and it ends every command with a one-cycle `done` pulse carrying a result code. Both doorbell waits are bounded by a cycle timeout. When that timeout expires, one last read is made before the engine gives up.

Top module: `mbx_seq`

## Requirements
- R1: After reset, `done` and `bus_req` are low.
- R2: If `out_len` exceeds `payload_size` at `start`, the command ends with result TOO_BIG (code 1) and copy count 0, and no register access is made.
- R3: A doorbell wait reads the control register (select 0, doorbell at bit 0) until bit 0 reads 0. When a read returning 1 completes TIMEOUT_CYC or more cycles after the wait began, exactly one further read is made. If that read is also 1, the result is TIMEOUT (code 4) with copy count 0. This applies both before submission and after the doorbell is rung.
- R4: The status word (select 3) permits submission only if bit 4 is 1 and bits [3:2] equal 1. Otherwise the result is BUSY (code 2), and no command is written.
- R5: If the status word passes R4 but bit 0, bit 1 or any of bits [7:5] is set, the result is FAULT (code 3), and no command is written.
- R6: After the status check, the doorbell is read once more; if it is 1 the result is BUSY. Otherwise the command register (select 1) is written with the opcode in bits [15:0] and the input length in bits [36:16]. After that, the control register is written with bit 0 set.
- R7: After the doorbell clears, the status register (select 2) is read. A nonzero return code in bits [47:32] gives DEV_ERR (code 5) with copy count 0, and the command register is not read.
- R8: On a zero return code, the command register is read. The copy count is the minimum of the requested length, the payload size and the reported length in bits [36:16]. A reported length of 0 gives a count of 0.
- R9: The result is OK (code 0) when the copy count equals the expected output length, and SIZE_ERR (code 6) otherwise.
- R10: `done` is high for exactly one cycle per command. A `start` that arrives while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (sampled when idle) |
| opcode | input | 16 | Command opcode |
| in_len | input | 21 | Input payload length in bytes |
| out_len | input | 21 | Expected output length in bytes |
| payload_size | input | 21 | Mailbox payload capacity in bytes |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | Access is a write |
| bus_sel | output | 2 | Register select: 0 control, 1 command, 2 status, 3 device status |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access complete; read data valid this cycle |
| bus_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with done |
| copy_len | output | 21 | Bytes the requester may copy, valid with done |

## Verification
The sharpest coincidence is a doorbell read that returns clear in the same cycle the timeout has expired. A clear read must win and the command must proceed, with no timeout. The bench sweeps the number of busy doorbell reads in both wait phases so that the clearing read falls just before expiry, exactly on the single recheck, and one read after it. It expects OK, OK and TIMEOUT respectively. A second coincidence is a `start` pulse issued while a command is in flight. This is judged by counting the command writes and the `done` pulses seen by the device model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_TOO_BIG  = 3'd1,
        RES_BUSY     = 3'd2,
        RES_FAULT    = 3'd3,
        RES_TIMEOUT  = 3'd4,
        RES_DEV_ERR  = 3'd5,
        RES_SIZE_ERR = 3'd6
    } mbx_res_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DEV  = 2'd3
    } mbx_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DB1,
        ST_DB1_RE,
        ST_DEV,
        ST_CHK,
        ST_CMD,
        ST_RING,
        ST_DB2,
        ST_DB2_RE,
        ST_STAT,
        ST_RDCMD
    } mbx_state_e;

    // field positions decoded by the device side
    localparam int unsigned DOORBELL_BIT = 0;
    localparam int unsigned LEN_LSB      = 16;
    localparam int unsigned RC_LSB       = 32;
    localparam int unsigned RC_W         = 16;
    localparam int unsigned DS_FATAL     = 0;
    localparam int unsigned DS_HALT      = 1;
    localparam int unsigned DS_MEDIA_LSB = 2;
    localparam int unsigned DS_IF_RDY    = 4;
    localparam int unsigned DS_RST_LSB   = 5;

endpackage

// File: rtl/mbx_timer.sv
module mbx_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        if (clr) begin
            count_d = '0;
        end else if (count_q >= W'(LIMIT)) begin
            count_d = count_q;
        end else begin
            count_d = count_q + W'(1);
        end
    end

    assign expired = (count_q >= W'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end
endmodule

// File: rtl/mbx_clamp.sv
module mbx_clamp #(
    parameter int unsigned W = 21
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] m
);
    logic [W-1:0] ab;

    always_comb begin
        ab = (a < b) ? a : b;
        m  = (ab < c) ? ab : c;
    end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned OPC_W       = 16,
    parameter int unsigned LEN_W       = 21,
    parameter int unsigned DATA_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [LEN_W-1:0]  out_len,
    input  logic [LEN_W-1:0]  payload_size,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_sel,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [2:0]        result,
    output logic [LEN_W-1:0]  copy_len
);
    typedef struct packed {
        mbx_state_e       st;
        logic [OPC_W-1:0] opc;
        logic [LEN_W-1:0] in_len;
        logic [LEN_W-1:0] out_len;
        logic [LEN_W-1:0] pay;
        logic [LEN_W-1:0] copy;
        mbx_res_e         res;
        logic             done;
    } seq_s;

    seq_s s_d, s_q;
    logic             tmr_clr;
    logic             tmr_exp;
    logic [LEN_W-1:0] clamp_n;
    logic [LEN_W-1:0] rep_len;
    logic [7:0]       dstat;
    logic             db_set;
    logic [RC_W-1:0]  rc;
    logic [LEN_W-1:0] want_len_q;

    assign rep_len    = bus_rdata[LEN_LSB +: LEN_W];
    assign dstat      = bus_rdata[7:0];
    assign db_set     = bus_rdata[DOORBELL_BIT];
    assign rc         = bus_rdata[RC_LSB +: RC_W];
    assign want_len_q = s_q.out_len;

    mbx_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .expired (tmr_exp)
    );

    mbx_clamp #(.W(LEN_W)) i_clamp (
        .a (s_q.out_len),
        .b (s_q.pay),
        .c (rep_len),
        .m (clamp_n)
    );

    // register port driven from the current state only
    always_comb begin
        bus_req   = (s_q.st != ST_IDLE);
        bus_we    = (s_q.st == ST_CMD) || (s_q.st == ST_RING);
        bus_wdata = '0;
        unique case (s_q.st)
            ST_DEV:            bus_sel = SEL_DEV;
            ST_CMD, ST_RDCMD:  bus_sel = SEL_CMD;
            ST_STAT:           bus_sel = SEL_STAT;
            default:           bus_sel = SEL_CTRL;
        endcase
        if (s_q.st == ST_CMD) begin
            bus_wdata[OPC_W-1:0]           = s_q.opc;
            bus_wdata[LEN_LSB +: LEN_W]    = s_q.in_len;
        end else if (s_q.st == ST_RING) begin
            bus_wdata[DOORBELL_BIT]        = 1'b1;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_clr  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.opc     = opcode;
                    s_d.in_len  = in_len;
                    s_d.out_len = out_len;
                    s_d.pay     = payload_size;
                    if (out_len > payload_size) begin
                        s_d.done = 1'b1;
                        s_d.res  = RES_TOO_BIG;
                        s_d.copy = '0;
                    end else begin
                        s_d.st  = ST_DB1;
                        tmr_clr = 1'b1;
                    end
                end
            end
            ST_DB1, ST_DB2: begin
                if (bus_ack) begin
                    if (!db_set) begin
                        s_d.st = (s_q.st == ST_DB1) ? ST_DEV : ST_STAT;
                    end else if (tmr_exp) begin
                        s_d.st = (s_q.st == ST_DB1) ? ST_DB1_RE : ST_DB2_RE;
                    end
                end
            end
            ST_DB1_RE, ST_DB2_RE: begin
                if (bus_ack) begin
                    if (!db_set) begin
                        s_d.st = (s_q.st == ST_DB1_RE) ? ST_DEV : ST_STAT;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_TIMEOUT;
                        s_d.copy = '0;
                    end
                end
            end
            ST_DEV: begin
                if (bus_ack) begin
                    if (!(dstat[DS_IF_RDY] &&
                          (dstat[DS_MEDIA_LSB +: 2] == 2'd1))) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_BUSY;
                        s_d.copy = '0;
                    end else if (dstat[DS_FATAL] || dstat[DS_HALT] ||
                                 (dstat[DS_RST_LSB +: 3] != 3'd0)) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_FAULT;
                        s_d.copy = '0;
                    end else begin
                        s_d.st = ST_CHK;
                    end
                end
            end
            ST_CHK: begin
                if (bus_ack) begin
                    if (db_set) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_BUSY;
                        s_d.copy = '0;
                    end else begin
                        s_d.st = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (bus_ack) s_d.st = ST_RING;
            end
            ST_RING: begin
                if (bus_ack) begin
                    s_d.st  = ST_DB2;
                    tmr_clr = 1'b1;
                end
            end
            ST_STAT: begin
                if (bus_ack) begin
                    if (rc != '0) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_DEV_ERR;
                        s_d.copy = '0;
                    end else begin
                        s_d.st = ST_RDCMD;
                    end
                end
            end
            ST_RDCMD: begin
                if (bus_ack) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.copy = clamp_n;
                    s_d.res  = (clamp_n == s_q.out_len) ? RES_OK : RES_SIZE_ERR;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st      <= ST_IDLE;
            s_q.opc     <= '0;
            s_q.in_len  <= '0;
            s_q.out_len <= '0;
            s_q.pay     <= '0;
            s_q.copy    <= '0;
            s_q.res     <= RES_OK;
            s_q.done    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done     = s_q.done;
    assign result   = s_q.res;
    assign copy_len = s_q.copy;
endmodule

// File: rtl/mbx_seq_chk.sv
module mbx_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic [2:0]  result,
    input logic [20:0] copy_len,
    input logic        bus_req,
    input logic        bus_ack,
    input logic        bus_we,
    input logic [1:0]  bus_sel,
    input logic [63:0] bus_wdata,
    input logic [20:0] want_len_q
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    // R2
    too_big_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd1) |-> (copy_len == '0));

    // R7
    dev_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd5) |-> (copy_len == '0));

    // R9
    ok_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd0) |-> (copy_len == want_len_q));

    // R6
    ring_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_sel == 2'd0) |-> bus_wdata[0]);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_sel) &&
                                   $stable(bus_we) && $stable(bus_wdata)));
endmodule

bind mbx_seq mbx_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .result     (result),
    .copy_len   (copy_len),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .bus_we     (bus_we),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .want_len_q (want_len_q)
);

// File: tb/test_mbx_seq.sv
module test_mbx_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 20;

    typedef struct packed {
        logic [9:0]  pre;
        logic        chkb;
        logic [9:0]  post;
        logic [7:0]  dev;
        logic [15:0] rc;
        logic [20:0] rep;
        logic [20:0] outl;
        logic [20:0] pay;
        logic [2:0]  res;
        logic [20:0] copy;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'd0, 21'd64,  21'd64,  21'd256, 3'd0, 21'd64},
        '{10'd3, 1'b0, 10'd5, 8'h14, 16'd0, 21'd128, 21'd128, 21'd256, 3'd0, 21'd128},
        '{10'd0, 1'b0, 10'd1, 8'h14, 16'd0, 21'd300, 21'd256, 21'd256, 3'd0, 21'd256},
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'd0, 21'd100, 21'd80,  21'd256, 3'd0, 21'd80},
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'd0, 21'd40,  21'd80,  21'd256, 3'd6, 21'd40},
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'd0, 21'd0,   21'd16,  21'd256, 3'd6, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'd0, 21'd0,   21'd0,   21'd256, 3'd0, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'd0, 21'd64,  21'd300, 21'd256, 3'd1, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h04, 16'd0, 21'd64,  21'd64,  21'd256, 3'd2, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h18, 16'd0, 21'd64,  21'd64,  21'd256, 3'd2, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h1C, 16'd0, 21'd64,  21'd64,  21'd256, 3'd2, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h11, 16'd0, 21'd64,  21'd64,  21'd256, 3'd2, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h15, 16'd0, 21'd64,  21'd64,  21'd256, 3'd3, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h16, 16'd0, 21'd64,  21'd64,  21'd256, 3'd3, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h34, 16'd0, 21'd64,  21'd64,  21'd256, 3'd3, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'hF4, 16'd0, 21'd64,  21'd64,  21'd256, 3'd3, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'd5, 21'd64,  21'd64,  21'd256, 3'd5, 21'd0},
        '{10'd0, 1'b0, 10'd0, 8'h14, 16'h8000, 21'd64, 21'd64, 21'd256, 3'd5, 21'd0},
        '{10'd0, 1'b1, 10'd0, 8'h14, 16'd0, 21'd64,  21'd64,  21'd256, 3'd2, 21'd0},
        '{10'd10, 1'b0, 10'd0, 8'h14, 16'd0, 21'd64, 21'd64,  21'd256, 3'd0, 21'd64},
        '{10'd11, 1'b0, 10'd0, 8'h14, 16'd0, 21'd64, 21'd64,  21'd256, 3'd0, 21'd64},
        '{10'd12, 1'b0, 10'd0, 8'h14, 16'd0, 21'd64, 21'd64,  21'd256, 3'd4, 21'd0},
        '{10'd0, 1'b0, 10'd10, 8'h14, 16'd0, 21'd64, 21'd64,  21'd256, 3'd0, 21'd64},
        '{10'd0, 1'b0, 10'd11, 8'h14, 16'd0, 21'd64, 21'd64,  21'd256, 3'd0, 21'd64},
        '{10'd0, 1'b0, 10'd12, 8'h14, 16'd0, 21'd64, 21'd64,  21'd256, 3'd4, 21'd0},
        '{10'd0, 1'b0, 10'd1000, 8'h14, 16'd0, 21'd64, 21'd64, 21'd256, 3'd4, 21'd0},
        '{10'd1000, 1'b0, 10'd0, 8'h14, 16'd0, 21'd64, 21'd64, 21'd256, 3'd4, 21'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [20:0] in_len = '0;
    logic [20:0] out_len = '0;
    logic [20:0] payload_size = '0;
    logic        bus_req, bus_we;
    logic [1:0]  bus_sel;
    logic [63:0] bus_wdata;
    logic        bus_ack;
    logic [63:0] bus_rdata;
    logic        done;
    logic [2:0]  result;
    logic [20:0] copy_len;

    // device model configuration (written by the stimulus only)
    int          m_pre = 0, m_post = 0;
    logic        m_chkb = 1'b0;
    logic [7:0]  m_dev = 8'h14;
    logic [15:0] m_rc = '0;
    logic [20:0] m_rep = '0;
    logic        m_clr = 1'b0;

    // device model state (written by the model only)
    logic        ack_q;
    logic [63:0] rdata_q;
    logic        rung, chk_pend;
    int          pre_idx, post_idx, acc_cnt, cmd_wr_cnt, cmd_rd_cnt;
    int          ring_cnt, cmd_wr_at, ring_at, done_cnt;
    logic [63:0] cmd_wr_val;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_seq #(.TIMEOUT_CYC(TO)) i_mbx_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .opcode       (opcode),
        .in_len       (in_len),
        .out_len      (out_len),
        .payload_size (payload_size),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_sel      (bus_sel),
        .bus_wdata    (bus_wdata),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .done         (done),
        .result       (result),
        .copy_len     (copy_len)
    );

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;

    always @(posedge clk) begin
        if (!rst_n || m_clr) begin
            ack_q <= 1'b0; rdata_q <= '0; rung <= 1'b0; chk_pend <= 1'b0;
            pre_idx <= 0; post_idx <= 0; acc_cnt <= 0; cmd_wr_cnt <= 0;
            cmd_rd_cnt <= 0; ring_cnt <= 0; cmd_wr_at <= -1; ring_at <= -1;
            done_cnt <= 0; cmd_wr_val <= '0;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            ack_q <= bus_req && !ack_q;
            if (bus_req && !ack_q) begin
                acc_cnt <= acc_cnt + 1;
                rdata_q <= '0;
                case (bus_sel)
                    2'd0: begin
                        if (bus_we) begin
                            rung <= 1'b1; ring_cnt <= ring_cnt + 1; ring_at <= acc_cnt;
                        end else if (!rung) begin
                            rdata_q <= {63'd0, (chk_pend || pre_idx < m_pre)};
                            chk_pend <= 1'b0;
                            pre_idx <= pre_idx + 1;
                        end else begin
                            rdata_q <= {63'd0, (post_idx < m_post)};
                            post_idx <= post_idx + 1;
                        end
                    end
                    2'd1: begin
                        if (bus_we) begin
                            cmd_wr_cnt <= cmd_wr_cnt + 1;
                            cmd_wr_val <= bus_wdata;
                            cmd_wr_at  <= acc_cnt;
                        end else begin
                            cmd_rd_cnt <= cmd_rd_cnt + 1;
                            rdata_q <= 64'(m_rep) << 16;
                        end
                    end
                    2'd2: rdata_q <= 64'(m_rc) << 32;
                    default: begin
                        rdata_q  <= {56'd0, m_dev};
                        chk_pend <= m_chkb;
                    end
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk); m_clr = 1'b1;
        @(negedge clk); m_clr = 1'b0;
    endtask

    // issue one command, wait for done, leave result sampled at negedge
    task automatic run_cmd(input logic [15:0] opc, input logic [20:0] il,
                           input logic [20:0] ol, input logic [20:0] pl,
                           output logic [2:0] r, output logic [20:0] c);
        int guard = 0;
        @(negedge clk);
        opcode = opc; in_len = il; out_len = ol; payload_size = pl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        r = result; c = copy_len;
        if (guard >= 5000) chk("R10 done never seen", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] res);
        case (res)
            3'd0: return "R8";
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R3";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0]  r;
        logic [20:0] c;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 bus_req", bus_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus_req after release", bus_req, 0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] opc;
            logic [20:0] il;
            opc = 16'h4000 + 16'(i);
            il  = 21'(i * 3);
            m_pre = int'(VECS[i].pre); m_post = int'(VECS[i].post);
            m_chkb = VECS[i].chkb; m_dev = VECS[i].dev;
            m_rc = VECS[i].rc; m_rep = VECS[i].rep;
            clear_model();
            run_cmd(opc, il, VECS[i].outl, VECS[i].pay, r, c);
            chk($sformatf("%s vec%0d result", tag_of(VECS[i].res), i), r, VECS[i].res);
            chk($sformatf("%s vec%0d copy", tag_of(VECS[i].res), i), c, VECS[i].copy);
            chk($sformatf("R10 vec%0d done count", i), done_cnt, 1);
            case (VECS[i].res)
                3'd0, 3'd6: begin
                    // R6 command contents and ordering
                    chk($sformatf("R6 vec%0d cmd word", i), cmd_wr_val,
                        (64'(il) << 16) | 64'(opc));
                    chk($sformatf("R6 vec%0d ring count", i), ring_cnt, 1);
                    chk($sformatf("R6 vec%0d cmd before ring", i), cmd_wr_at < ring_at, 1);
                end
                3'd1: chk($sformatf("R2 vec%0d no access", i), acc_cnt, 0);
                3'd2, 3'd3: chk($sformatf("R4 R5 vec%0d no cmd write", i), cmd_wr_cnt, 0);
                3'd5: chk($sformatf("R7 vec%0d cmd not read", i), cmd_rd_cnt, 0);
                default: ;
            endcase
        end

        // R10 start while busy is ignored
        m_pre = 0; m_post = 4; m_chkb = 0; m_dev = 8'h14; m_rc = 0; m_rep = 21'd32;
        clear_model();
        @(negedge clk);
        opcode = 16'h0123; in_len = 21'd7; out_len = 21'd32; payload_size = 21'd256;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        opcode = 16'h0BAD; out_len = 21'd500; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        chk("R10 single command write", cmd_wr_cnt, 1);
        chk("R10 first opcode kept", cmd_wr_val[15:0], 16'h0123);
        chk("R10 single done", done_cnt, 1);
        chk("R10 result of first", result, 3'd0);
        chk("R10 copy of first", copy_len, 21'd32);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule